// File: doc/BRIEF.md
# SMBus Byte-Register Slave with Alert Response

This block is the serial front end of a small peripheral that exposes a bank of 8-bit registers over a two-wire SMBus/I2C link. It serves the two byte-wide register transactions: a write that carries a command byte and one data byte, and a read that carries a command byte, a repeated START, and one returned data byte. The command byte goes straight to the register side as the register address. The block does not hold the register bank itself. It presents an address, write data and a write strobe, and it takes read data back on the same cycle as its read strobe.

The slave address is seven bits. The upper four come from a parameter, and the lower three are captured from strap pins while reset is held. When the register side reports a pending alert, the block also answers a read to the alert response address by returning its own address. It sends each bit through an open-drain pull-down, so that a device with a lower address wins the wired-AND contest. A complete answer produces a one-cycle pulse that the register side uses to clear its alert.

SCL and SDA arrive already synchronized to the system clock and are oversampled. The only output toward the bus is the pull-down enable for SDA. The slave never stretches the clock.

Top module: `smbRegSlave`

## Requirements
- R1: A write transaction (START, own address with bit0=0, command byte, data byte) is ACKed on all three bytes and gives exactly one `regWrEn` pulse, with `regAddr` equal to the command byte and `regWrData` equal to the data byte.
- R2: A read transaction (START, own address write, command, repeated START, own address with bit0=1) returns `regRdData` of the addressed register MSB first and raises `regRdEn` for exactly one cycle per transaction, in the cycle the byte is loaded.
- R3: The own address is {ADDR_HI, strap}, where the strap is the value of `strapAddr` while `rstN` is low. Strap changes after reset have no effect, and bytes naming any other address are not ACKed and cause no strobe.
- R4: The alert response address byte 0x19 (7'b0001100 plus read bit) is ACKed only while `alertPending` is 1. The slave then returns {own address, 0} MSB first and pulses `araDone` once after the eighth bit.
- R5: While sending the alert answer, if the slave leaves SDA released for a 1 and samples SDA low at the SCL rising edge, it stops driving for the rest of the transaction and gives no `araDone`.
- R6: The ACK is a pull-down held for the ninth SCL clock, and `sdaPullDn` changes only while SCL is low.
- R7: A START or STOP seen mid-transaction restarts the state machine, so a STOP after the command byte writes nothing, and a repeated START begins a fresh address phase.
- R8: After one data byte of a write, further bytes are neither ACKed nor written. After the read or alert byte, the slave leaves SDA released until the next START.
- R9: After reset, `sdaPullDn`, `regWrEn`, `regRdEn` and `araDone` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Active-low reset; strap pins captured while low |
| sclIn | input | 1 | Synchronized SCL level |
| sdaIn | input | 1 | Synchronized SDA level |
| strapAddr | input | 3 | Low slave address bits, captured during reset |
| sdaPullDn | output | 1 | 1 pulls SDA low |
| regAddr | output | 8 | Register address (last command byte) |
| regWrData | output | 8 | Write data, valid with regWrEn |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdData | input | 8 | Read data of regAddr, sampled with regRdEn |
| regRdEn | output | 1 | One-cycle register read strobe |
| alertPending | input | 1 | Register side has an alert outstanding |
| araDone | output | 1 | One-cycle pulse: alert answer completed |

## Verification
The alert function and the register function meet when an alert is raised while an ordinary read of a register is under way. The read strobe of that read and the pending alert are then live in the same transaction. The bench raises `alertPending` before a read, checks that the read returns the register value with a single strobe and no `araDone`, and then checks that the following alert response transaction answers and pulses `araDone`. A second overlap is the arbitration loss inside the alert answer: a competing lower address is driven on the same bits, and the bench judges that the bus carries the winner's byte and that no `araDone` pulse appears.

// File: rtl/smbSlavePkg.sv
package smbSlavePkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam logic [6:0] ARA_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_ACK, ST_TX, ST_WAIT
  } smbState_e;

  typedef struct packed {
    logic shiftIn;
    logic latchCmd;
    logic loadRead;
    logic loadAra;
    logic shiftOut;
  } dpCtl_t;
endpackage

// File: rtl/smbSlaveDp.sv
module smbSlaveDp
  import smbSlavePkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  input  dpCtl_t             ctl,
  input  logic [BYTE_W-1:0]  regRdData,
  output logic [BYTE_W-1:0]  rxByte,
  output logic [BYTE_W-1:0]  regAddr,
  output logic               addrIsOwnW,
  output logic               addrIsOwnR,
  output logic               addrIsAra,
  output logic               txMsb,
  output logic               txNextBit
);
  localparam int ADDR_W = 4 + STRAP_W;

  logic [STRAP_W-1:0] strapQ;
  logic [ADDR_W-1:0]  ownAddr;
  logic [BYTE_W-1:0]  rxShift, txShift;

  // strap capture: follows the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) strapQ <= strapAddr;
  end

  assign ownAddr = {ADDR_HI, strapQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      regAddr <= '0;
    end else begin
      if (ctl.shiftIn)  rxShift <= {rxShift[BYTE_W-2:0], sdaIn};
      if (ctl.latchCmd) regAddr <= rxShift;
      if (ctl.loadRead)      txShift <= regRdData;
      else if (ctl.loadAra)  txShift <= {ownAddr, 1'b0};
      else if (ctl.shiftOut) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign rxByte     = rxShift;
  assign addrIsOwnW = (rxShift == {ownAddr, 1'b0});
  assign addrIsOwnR = (rxShift == {ownAddr, 1'b1});
  assign addrIsAra  = (rxShift == {ARA_ADDR, 1'b1});
  assign txMsb      = txShift[BYTE_W-1];
  assign txNextBit  = ctl.loadRead ? regRdData[BYTE_W-1] :
                      ctl.loadAra  ? ownAddr[ADDR_W-1]   :
                                     txShift[BYTE_W-2];

  // R2 / R4: only one shift-register action per cycle
  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.shiftIn, ctl.loadRead, ctl.loadAra, ctl.shiftOut}));

  // R3: captured strap never moves once reset is released
  a_r3_strap_held: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(strapQ));
endmodule

// File: rtl/smbSlaveCtrl.sv
module smbSlaveCtrl
  import smbSlavePkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  logic   addrIsOwnW,
  input  logic   addrIsOwnR,
  input  logic   addrIsAra,
  input  logic   txMsb,
  input  logic   txNextBit,
  input  logic   alertPending,
  output dpCtl_t ctl,
  output logic   sdaPullDn,
  output logic   regWrEn,
  output logic   regRdEn,
  output logic   araDone
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  smbState_e        state, ackNext;
  logic             nextTx, nextAra, isAra;
  logic [CNT_W-1:0] bitCnt;
  logic             sclQ, sdaQ;
  logic             sclRise, sclFall, startDet, stopDet, rxState;

  assign sclRise  = sclIn & ~sclQ;
  assign sclFall  = ~sclIn & sclQ;
  assign startDet = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopDet  = sclIn & sclQ & ~sdaQ & sdaIn;
  assign rxState  = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDATA);

  always_comb begin
    ctl          = '0;
    ctl.shiftIn  = sclRise & rxState & (bitCnt < LAST_BIT);
    ctl.latchCmd = sclFall & (state == ST_CMD) & (bitCnt == LAST_BIT);
    ctl.loadRead = sclFall & (state == ST_ACK) & nextTx & ~nextAra;
    ctl.loadAra  = sclFall & (state == ST_ACK) & nextTx & nextAra;
    ctl.shiftOut = sclFall & (state == ST_TX) & (bitCnt < LAST_BIT);
  end

  assign regRdEn = ctl.loadRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackNext   <= ST_IDLE;
      nextTx    <= 1'b0;
      nextAra   <= 1'b0;
      isAra     <= 1'b0;
      bitCnt    <= '0;
      sdaPullDn <= 1'b0;
      regWrEn   <= 1'b0;
      araDone   <= 1'b0;
    end else begin
      regWrEn <= 1'b0;
      araDone <= 1'b0;
      if (startDet) begin
        state     <= ST_ADDR;
        bitCnt    <= '0;
        sdaPullDn <= 1'b0;
      end else if (stopDet) begin
        state     <= ST_IDLE;
        sdaPullDn <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (sclRise && bitCnt < LAST_BIT) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == LAST_BIT) begin
              bitCnt  <= '0;
              nextTx  <= 1'b0;
              nextAra <= 1'b0;
              if (state == ST_ADDR) begin
                if (addrIsOwnW) begin
                  state <= ST_ACK; sdaPullDn <= 1'b1; ackNext <= ST_CMD;
                end else if (addrIsOwnR) begin
                  state <= ST_ACK; sdaPullDn <= 1'b1; nextTx <= 1'b1;
                end else if (addrIsAra && alertPending) begin
                  state <= ST_ACK; sdaPullDn <= 1'b1; nextTx <= 1'b1; nextAra <= 1'b1;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_CMD) begin
                state <= ST_ACK; sdaPullDn <= 1'b1; ackNext <= ST_WDATA;
              end else begin
                state <= ST_ACK; sdaPullDn <= 1'b1; ackNext <= ST_WAIT;
                regWrEn <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (nextTx) begin
                state     <= ST_TX;
                isAra     <= nextAra;
                sdaPullDn <= ~txNextBit;
              end else begin
                state     <= ackNext;
                sdaPullDn <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
              if (isAra && txMsb && !sdaIn) begin
                state     <= ST_WAIT;
                sdaPullDn <= 1'b0;
              end
            end else if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                state     <= ST_WAIT;
                sdaPullDn <= 1'b0;
                araDone   <= isAra;
              end else begin
                sdaPullDn <= ~txNextBit;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: the pull-down only moves while SCL is low
  a_r6_pull_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullDn) |-> !$past(sclIn));

  // R8: idle and waiting states leave SDA released
  a_r8_released_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_WAIT) |-> !sdaPullDn);

  // R1: write strobe coincides with the start of the data ACK
  a_r1_write_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (sdaPullDn && state == ST_ACK));

  // R4: the alert answer pulse is a single cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    araDone |=> !araDone);
endmodule

// File: rtl/smbRegSlave.sv
module smbRegSlave
  import smbSlavePkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  output logic               sdaPullDn,
  output logic [BYTE_W-1:0]  regAddr,
  output logic [BYTE_W-1:0]  regWrData,
  output logic               regWrEn,
  input  logic [BYTE_W-1:0]  regRdData,
  output logic               regRdEn,
  input  logic               alertPending,
  output logic               araDone
);
  dpCtl_t ctl;
  logic   addrIsOwnW, addrIsOwnR, addrIsAra, txMsb, txNextBit;

  smbSlaveCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrIsOwnW(addrIsOwnW), .addrIsOwnR(addrIsOwnR), .addrIsAra(addrIsAra),
    .txMsb(txMsb), .txNextBit(txNextBit), .alertPending(alertPending),
    .ctl(ctl), .sdaPullDn(sdaPullDn), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .araDone(araDone)
  );

  smbSlaveDp #(.ADDR_HI(ADDR_HI)) uDp (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .strapAddr(strapAddr),
    .ctl(ctl), .regRdData(regRdData), .rxByte(regWrData), .regAddr(regAddr),
    .addrIsOwnW(addrIsOwnW), .addrIsOwnR(addrIsOwnR), .addrIsAra(addrIsAra),
    .txMsb(txMsb), .txNextBit(txNextBit)
  );
endmodule

// File: tb/tb_smbRegSlave.sv
`timescale 1ns/1ps
module tb_smbRegSlave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic alert = 1'b0;
  logic sdaPullDn, regWrEn, regRdEn, araDone, sdaBus;
  logic [7:0] regAddr, regWrData, regRdData;
  logic [7:0] regs [8];
  int nChecks = 0, nFail = 0, wrCount = 0, rdCount = 0, araCount = 0;

  always #2 clk = ~clk;

  assign sdaBus    = sdaM & ~sdaPullDn;
  assign regRdData = regs[regAddr[2:0]];

  smbRegSlave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapAddr(strap),
    .sdaPullDn(sdaPullDn), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .regRdEn(regRdEn),
    .alertPending(alert), .araDone(araDone)
  );

  always @(negedge clk) begin
    if (regWrEn) begin regs[regAddr[2:0]] <= regWrData; wrCount++; end
    if (regRdEn) rdCount++;
    if (araDone) araCount++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ; repeat (6) @(posedge clk); #1; endtask

  task automatic smbStart;
    sdaM = 1; waitQ; sclM = 1; waitQ; sdaM = 0; waitQ; sclM = 0; waitQ;
  endtask

  task automatic smbStop;
    sdaM = 0; waitQ; sclM = 1; waitQ; sdaM = 1; waitQ;
  endtask

  task automatic clockBit(input bit drv, output bit seen);
    sdaM = drv; waitQ; sclM = 1; waitQ; seen = sdaBus; waitQ; sclM = 0; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ack = !s;
  endtask

  // drv = bits a competing device drives (FF = none)
  task automatic recvByte(input logic [7:0] drv, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin clockBit(drv[i], s); d[i] = s; end
    clockBit(1'b1, s);  // master NACK
  endtask

  task automatic doReset(input logic [2:0] s);
    strap = s; rstN = 0; repeat (4) @(posedge clk); #1; rstN = 1; waitQ;
  endtask

  task automatic writeReg(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                          output bit a0, output bit a1, output bit a2);
    smbStart; sendByte({a, 1'b0}, a0); sendByte(c, a1); sendByte(d, a2); smbStop;
  endtask

  task automatic readReg(input logic [6:0] a, input logic [7:0] c, output logic [7:0] d,
                         output bit allAck);
    bit k0, k1, k2;
    smbStart; sendByte({a, 1'b0}, k0); sendByte(c, k1);
    smbStart; sendByte({a, 1'b1}, k2); recvByte(8'hFF, d); smbStop;
    allAck = k0 & k1 & k2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    bit k0, k1, k2, k3, ok;
    logic [7:0] d, exp;
    int w0, r0, a0;
    logic [6:0] own;
    for (int i = 0; i < 8; i++) regs[i] = 8'h00;
    doReset(3'b101);
    own = {4'b0100, 3'b101};

    // R9 reset state
    check(!sdaPullDn && !regWrEn && !regRdEn && !araDone, "R9 reset outputs",
          {sdaPullDn, regWrEn, regRdEn, araDone}, 0);

    // R1 write sweep over all registers
    for (int r = 0; r < 8; r++) begin
      exp = 8'((r * 53 + 17) & 8'hFF);
      w0 = wrCount;
      writeReg(own, 8'(r), exp, k0, k1, k2);
      check(k0 && k1 && k2, "R1/R6 three ACKs", {k0, k1, k2}, 7);
      check(regs[r] == exp && wrCount == w0 + 1, "R1 write data", regs[r], exp);
    end

    // R2 read sweep
    for (int r = 0; r < 8; r++) begin
      exp = 8'((r * 53 + 17) & 8'hFF);
      r0 = rdCount;
      readReg(own, 8'(r), d, ok);
      check(ok && d == exp, "R2 read data", d, exp);
      check(rdCount == r0 + 1, "R2 one read strobe", rdCount - r0, 1);
    end

    // R8 extra data byte not acked nor written
    w0 = wrCount;
    smbStart; sendByte({own, 1'b0}, k0); sendByte(8'd6, k1);
    sendByte(8'hA5, k2); sendByte(8'h3C, k3); smbStop;
    check(!k3 && regs[6] == 8'hA5 && wrCount == w0 + 1, "R8 second data byte ignored",
          regs[6], 8'hA5);

    // R7 STOP after command writes nothing
    w0 = wrCount;
    smbStart; sendByte({own, 1'b0}, k0); sendByte(8'd2, k1); smbStop;
    check(wrCount == w0 && regs[2] == 8'((2 * 53 + 17) & 8'hFF), "R7 stop aborts write",
          wrCount - w0, 0);

    // R7 repeated START restarts address phase
    smbStart; sendByte({own, 1'b0}, k0); sendByte(8'd3, k1);
    smbStart; sendByte({own, 1'b0}, k0); sendByte(8'd4, k1); sendByte(8'h5E, k2); smbStop;
    check(regs[3] == 8'((3 * 53 + 17) & 8'hFF) && regs[4] == 8'h5E, "R7 restart", regs[4], 8'h5E);

    // R3 strap sweep: captured at reset, later pin changes ignored
    for (int s = 0; s < 8; s++) begin
      doReset(3'(s));
      strap = ~3'(s);
      w0 = wrCount;
      writeReg({4'b0100, ~3'(s)}, 8'd7, 8'h11, k0, k1, k2);
      check(!k0 && wrCount == w0, "R3 other strap ignored", k0, 0);
      writeReg({4'b0110, 3'(s)}, 8'd7, 8'h22, k0, k1, k2);
      check(!k0 && wrCount == w0, "R3 wrong upper bits", k0, 0);
      writeReg({4'b0100, 3'(s)}, 8'd7, 8'(s + 8'h40), k0, k1, k2);
      check(k0 && regs[7] == 8'(s + 8'h40), "R3 strapped address", regs[7], s + 8'h40);
    end
    doReset(3'b101);

    // R4 ARA ignored without alert
    a0 = araCount;
    smbStart; sendByte(8'h19, k0); smbStop;
    check(!k0 && araCount == a0, "R4 ARA without alert", k0, 0);

    // overlap: alert raised during ordinary read
    alert = 1;
    r0 = rdCount;
    readReg(own, 8'd5, d, ok);
    check(ok && d == 8'((5 * 53 + 17) & 8'hFF) && rdCount == r0 + 1 && araCount == a0,
          "R2 read with alert pending", d, 8'((5 * 53 + 17) & 8'hFF));

    // R4 ARA answered
    smbStart; sendByte(8'h19, k0); recvByte(8'hFF, d); smbStop;
    check(k0 && d == {own, 1'b0}, "R4 ARA returns own address", d, {own, 1'b0});
    check(araCount == a0 + 1, "R4 araDone once", araCount - a0, 1);
    alert = 0;

    // R5 arbitration lost to lower address 0x21
    alert = 1; a0 = araCount;
    smbStart; sendByte(8'h19, k0); recvByte({7'h21, 1'b0}, d); smbStop;
    check(d == {7'h21, 1'b0}, "R5 winner byte on bus", d, {7'h21, 1'b0});
    check(araCount == a0, "R5 no araDone after loss", araCount - a0, 0);
    alert = 0;

    // R8 released after transactions, normal read still works
    check(!sdaPullDn, "R8 bus released", sdaPullDn, 0);
    readReg(own, 8'd4, d, ok);
    check(ok && d == 8'h5E, "R2 read after arbitration", d, 8'h5E);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule